// File: doc/BRIEF.md
# Inter-Processor Message Command Register

This block is the command register that launches an inter-processor message. The register is 64 bits wide and split into two 32-bit halves that are accessed through a word-wide write and read port. Software loads the target processor id into the upper half first. It then writes the lower half, which holds the vector, delivery mode, level and trigger bits and a destination shorthand. Only the write to the lower half starts a send.

When a send is accepted, the block takes a snapshot of the command and presents it as a message record on a valid/ready output. The shorthand decides the destination. A zero shorthand uses the explicit id. The self shorthand uses this processor's own id, which the block gets from an input. Both broadcast shorthands drive an all-ones destination, and the shorthand code travels with the record.

A delivery-status bit in the lower half reads 1 from the accepted write until the handshake completes. Software polls this bit before it issues the next command. A lower-half write that arrives while the bit is 1 is dropped and raises a sticky error output. For startup messages, software places the start page number in the vector field, and the block forwards that field unchanged.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, both halves read 0, msg_valid_o is 0 and err_o is 0.
- R2: A write to the upper half (offset 0x310) stores bits 31:24 as the destination id. The other bits of that half read 0. The write starts no send.
- R3: A lower-half write (offset 0x300) while idle raises msg_valid_o on the next cycle. From that cycle, the lower half reads delivery status (bit 12) as 1.
- R4: The record carries the vector from bits 7:0, the delivery mode from bits 10:8, assert/deassert from bit 14 (1 = assert) and the trigger mode from bit 15, all unchanged. A startup page number placed in the vector therefore passes through as written.
- R5: The shorthand in bits 19:18 picks the destination. 00 gives the upper-half id, 01 gives self_id_i, and 10 (all including self) or 11 (all excluding self) gives 0xFF. The code appears on msg_short_o.
- R6: While msg_ready_i is 0, msg_valid_o stays 1 and the record stays stable. In the cycle after msg_valid_o and msg_ready_i are both 1, msg_valid_o and bit 12 read 0.
- R7: A lower-half write while delivery status is 1 is dropped. It sets err_o and leaves the pending record unchanged.
- R8: err_o stays set until the next accepted lower-half write, which clears it.
- R9: In the lower half, remote-read status (bits 17:16) always reads 00, meaning invalid. Bits 11, 13 and 31:20 read 0. The other fields read back as last accepted.
- R10: An upper-half write while a send is pending does not change the pending record's destination.
- R11: A write to any other offset changes neither half and starts no send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| self_id_i | input | 8 | Id of this processor, used for the self shorthand |
| msg_valid_o | output | 1 | Message record valid |
| msg_ready_i | input | 1 | Message interface accepts the record |
| msg_vector_o | output | 8 | Vector or startup page number |
| msg_mode_o | output | 3 | Delivery mode |
| msg_level_o | output | 1 | 1 = assert, 0 = deassert |
| msg_trig_o | output | 1 | Trigger mode |
| msg_short_o | output | 2 | Destination shorthand code |
| msg_dest_o | output | 8 | Resolved destination id |
| err_o | output | 1 | Sticky flag for a dropped send |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, the lower half at 0x300 and the upper half at 0x310, and 8-bit ids. With self_id_i held at 0x5A, the self shorthand resolves to a value that cannot be mistaken for the upper-half id or for the broadcast 0xFF. The bench holds msg_ready_i low for several cycles while it issues both an upper-half write and a colliding lower-half write. This brings the snapshot, drop and sticky-error paths within reach in one pending window.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int ID_W   = 8;

  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int BUSY_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int ID_LSB    = 24;

  typedef enum logic [1:0] {
    SH_NONE    = 2'b00,
    SH_SELF    = 2'b01,
    SH_ALL_INC = 2'b10,
    SH_ALL_EXC = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              level;
    logic              trig;
    shorthand_e        short;
    logic [ID_W-1:0]   dest;
  } msg_t;
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec #(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              lo_sel_o,
  output logic              hi_sel_o,
  output logic              lo_we_o,
  output logic              hi_we_o
);
  assign lo_sel_o = (addr_i == LO_OFF);
  assign hi_sel_o = (addr_i == HI_OFF);
  assign lo_we_o  = we_i && lo_sel_o;
  assign hi_we_o  = we_i && hi_sel_o;
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
  import ipi_cmd_pkg::*;
(
  input  shorthand_e      short_i,
  input  logic [ID_W-1:0] field_id_i,
  input  logic [ID_W-1:0] self_id_i,
  output logic [ID_W-1:0] dest_o
);
  always_comb begin
    unique case (short_i)
      SH_NONE:    dest_o = field_id_i;
      SH_SELF:    dest_o = self_id_i;
      default:    dest_o = {ID_W{1'b1}};  // broadcast, with or without self
    endcase
  end
endmodule

// File: rtl/ipi_send_ctl.sv
module ipi_send_ctl
  import ipi_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  msg_t cmd_i,
  input  logic ready_i,
  output logic busy_o,
  output logic err_o,
  output msg_t msg_o
);
  logic busy_q, err_q;
  msg_t msg_q;
  logic accept;

  assign accept = launch_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      msg_q  <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        msg_q  <= cmd_i;
        err_q  <= 1'b0;
      end else begin
        if (busy_q && ready_i) busy_q <= 1'b0;
        if (launch_i) err_q <= 1'b1;  // collision with a pending send
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign msg_o  = msg_q;

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && !busy_o |=> busy_o);  // R3
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ready_i |=> busy_o && $stable(msg_o));  // R6
  AST_HANDSHAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ready_i |=> !busy_o);  // R6
  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && busy_o |=> err_o && $stable(msg_o));  // R7
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && !busy_o |=> !err_o);  // R8
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_cmd_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [ID_W-1:0]   self_id_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [VEC_W-1:0]  msg_vector_o,
  output logic [MODE_W-1:0] msg_mode_o,
  output logic              msg_level_o,
  output logic              msg_trig_o,
  output logic [1:0]        msg_short_o,
  output logic [ID_W-1:0]   msg_dest_o,
  output logic              err_o
);
  logic lo_sel, hi_sel, lo_we, hi_we;
  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] dest_res;
  logic busy;
  msg_t cmd, msg;
  shorthand_e wr_short;

  ipi_addr_dec #(.ADDR_W(ADDR_W), .LO_OFF(LO_OFF), .HI_OFF(HI_OFF)) u_dec (
    .addr_i(addr_i), .we_i(we_i),
    .lo_sel_o(lo_sel), .hi_sel_o(hi_sel), .lo_we_o(lo_we), .hi_we_o(hi_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    id_q <= '0;
    else if (hi_we) id_q <= wdata_i[ID_LSB +: ID_W];
  end

  assign wr_short = shorthand_e'(wdata_i[SH_LSB +: 2]);

  ipi_dest_resolve u_res (
    .short_i(wr_short), .field_id_i(id_q), .self_id_i(self_id_i), .dest_o(dest_res)
  );

  always_comb begin
    cmd        = '0;
    cmd.vector = wdata_i[VEC_LSB +: VEC_W];
    cmd.mode   = wdata_i[MODE_LSB +: MODE_W];
    cmd.level  = wdata_i[LEVEL_BIT];
    cmd.trig   = wdata_i[TRIG_BIT];
    cmd.short  = wr_short;
    cmd.dest   = dest_res;
  end

  ipi_send_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(lo_we), .cmd_i(cmd),
    .ready_i(msg_ready_i), .busy_o(busy), .err_o(err_o), .msg_o(msg)
  );

  // Remote-read status (17:16) is never driven: reads 00, invalid
  always_comb begin
    rdata_o = '0;
    if (lo_sel) begin
      rdata_o[VEC_LSB +: VEC_W]   = msg.vector;
      rdata_o[MODE_LSB +: MODE_W] = msg.mode;
      rdata_o[BUSY_BIT]           = busy;
      rdata_o[LEVEL_BIT]          = msg.level;
      rdata_o[TRIG_BIT]           = msg.trig;
      rdata_o[SH_LSB +: 2]        = msg.short;
    end else if (hi_sel) begin
      rdata_o[ID_LSB +: ID_W]     = id_q;
    end
  end

  assign msg_valid_o  = busy;
  assign msg_vector_o = msg.vector;
  assign msg_mode_o   = msg.mode;
  assign msg_level_o  = msg.level;
  assign msg_trig_o   = msg.trig;
  assign msg_short_o  = msg.short;
  assign msg_dest_o   = msg.dest;

  AST_HI_WRITE_NO_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we && !msg_valid_o |=> !msg_valid_o);  // R2
  AST_DEST_STABLE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we && msg_valid_o && !msg_ready_i |=> $stable(msg_dest_o));  // R10
  AST_OTHER_OFF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !lo_sel && !hi_sel && !msg_valid_o |=> !msg_valid_o && $stable(id_q));  // R11
endmodule

// File: tb/ipi_cmd_reg_tb.sv
module ipi_cmd_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  self_id = 8'h5A;
  logic        valid, ready = 1'b0;
  logic [7:0]  vec, dest;
  logic [2:0]  mode;
  logic        level, trig, err;
  logic [1:0]  short;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [11:0] LO = 12'h300, HI = 12'h310;

  always #2 clk = ~clk;

  ipi_cmd_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .self_id_i(self_id), .msg_valid_o(valid), .msg_ready_i(ready),
    .msg_vector_o(vec), .msg_mode_o(mode), .msg_level_o(level), .msg_trig_o(trig),
    .msg_short_o(short), .msg_dest_o(dest), .err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  function automatic logic [31:0] lo_view(logic [31:0] d, logic b);
    return (d & 32'h000C_C7FF) | (32'(b) << 12);
  endfunction

  task automatic handshake();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(LO, r); chk("R1 lo", r, 0);
    rd(HI, r); chk("R1 hi", r, 0);
    chk("R1 valid", valid, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_hi();
    logic [31:0] r;
    wr(HI, 32'hABCD_EF12);
    rd(HI, r); chk("R2 hi", r, 32'hAB00_0000);
    chk("R2 no send", valid, 0);
  endtask

  task automatic t_main();
    logic [31:0] r, d;
    d = 32'hFFF3_7E40 & ~32'h000C_0000;  // shorthand 00, junk in reserved bits
    wr(LO, d);
    chk("R3 valid", valid, 1);
    rd(LO, r); chk("R3 busy", r[12], 1);
    chk("R9 lo view", r, lo_view(d, 1'b1));
    chk("R9 rr status", r[17:16], 0);
    chk("R4 vector", vec, 8'h40);
    chk("R4 mode", mode, 3'b110);
    chk("R4 level", level, d[14]);
    chk("R4 trig", trig, d[15]);
    chk("R5 dest field", dest, 8'hAB);
    chk("R5 short", short, 0);
    repeat (3) @(negedge clk);
    chk("R6 held", valid, 1);
    chk("R6 stable", vec, 8'h40);
    wr(HI, 32'h1100_0000);
    chk("R10 dest kept", dest, 8'hAB);
    wr(LO, 32'h0000_0199);
    chk("R7 err", err, 1);
    chk("R7 vector kept", vec, 8'h40);
    chk("R7 mode kept", mode, 3'b110);
    handshake();
    chk("R6 cleared", valid, 0);
    rd(LO, r); chk("R6 busy clr", r[12], 0);
    chk("R8 err sticky", err, 1);
  endtask

  task automatic t_short();
    logic [7:0] exp_d [4] = '{8'h11, 8'h5A, 8'hFF, 8'hFF};
    for (int s = 1; s < 4; s++) begin
      wr(LO, (32'(s) << 18) | 32'h0000_0608);  // startup-like page 0x08
      chk("R8 err clear", err, 0);
      chk("R5 short", short, s[1:0]);
      chk("R5 dest", dest, exp_d[s]);
      chk("R4 page vector", vec, 8'h08);
      handshake();
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] r0, h0, r;
    rd(LO, r0); rd(HI, h0);
    wr(12'h320, 32'hFFFF_FFFF);
    chk("R11 no send", valid, 0);
    rd(LO, r); chk("R11 lo", r, r0);
    rd(HI, r); chk("R11 hi", r, h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hi();
    t_main();
    t_short();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule